// File: doc/BRIEF.md
# USB Full-Speed Line Receiver

This block sits behind the two data lines of a full-speed USB port and turns what it sees on them into a stream of bytes with packet boundaries marked. It runs from a local sampling clock at `OSR` samples per bit time, four by default, which is 48 MHz for the 12 Mbit/s line rate. The two lines are brought into the clock domain by a two-flop synchroniser. The receiver then works in stages. It classifies each sample as J, K or SE0, and it rebuilds the bit timing from the line edges. It then decodes NRZI and strips the zeros that the transmitter inserted for stuffing. Last, it finds the SYNC pattern, packs bits into bytes and reports the end of each packet.

Each result appears as a one-cycle pulse on its own output. A packet produces a start pulse, then one byte strobe for each received byte, then exactly one of the following: end of packet, stuffing error, framing error or bus reset. Checking of packet IDs and CRCs is left to the logic downstream.

Top module: `usbfs_line_rx`

## Requirements
- R1: The synchronised line pair {dp, dm} is read as J when it is 2'b10, K when it is 2'b01 and SE0 when it is 2'b00. The receiver leaves reset assuming the idle J state.
- R2: In the hunting state, a 1 bit that follows at least six 0 bits raises `rx_sop` for one cycle and opens a packet. A shorter run of 0 bits followed by a 1 opens nothing.
- R3: The NRZI decoder yields 0 when the sampled line level changes between J and K from one bit time to the next, and 1 when the level stays the same.
- R4: Data bits are packed least significant bit first. Every eighth data bit after SYNC pulses `rx_valid` for one cycle, with the byte on `rx_byte`.
- R5: Inside a packet, the 0 bit that follows six consecutive 1 bits is discarded. The count of 1 bits includes the last bit of SYNC.
- R6: A 1 bit where a stuffed 0 was due raises `rx_stuff_err` for one cycle. The packet is then dropped, and no further byte or end-of-packet pulse follows until the next SYNC.
- R7: Inside a packet, two SE0 bit times followed by a J or K bit raise `rx_eop` for one cycle.
- R8: Inside a packet, a single SE0 bit time followed by a J or K bit raises `rx_frame_err` for one cycle instead of `rx_eop`.
- R9: SE0 that lasts `RST_CYCLES` consecutive samples (120 by default, 2.5 µs at 48 MHz) raises `rx_bus_reset` exactly once. This applies in or out of a packet, and a packet ended this way gives no `rx_eop`. SE0 of `RST_CYCLES-1` samples gives no reset.
- R10: The bit phase is realigned on every change of line state, so bits bounded by edges decode correctly at 3 or 5 samples wide.
- R11: At most one of `rx_valid`, `rx_sop`, `rx_eop`, `rx_stuff_err`, `rx_frame_err` and `rx_bus_reset` is high in any cycle. Bytes and packet endings occur only inside an open packet.
- R12: While reset is held and right after it, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, `OSR` times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| dp | input | 1 | Positive data line, asynchronous |
| dm | input | 1 | Negative data line, asynchronous |
| rx_valid | output | 1 | One-cycle strobe: `rx_byte` holds a new byte |
| rx_byte | output | 8 | Last received byte |
| rx_sop | output | 1 | One-cycle pulse: SYNC found, packet opened |
| rx_eop | output | 1 | One-cycle pulse: regular end of packet |
| rx_stuff_err | output | 1 | One-cycle pulse: bit stuffing violated |
| rx_frame_err | output | 1 | One-cycle pulse: SE0 too short to end a packet |
| rx_bus_reset | output | 1 | One-cycle pulse: SE0 held long enough to be a bus reset |

## Verification
The bench drives whole packets and compares the order of the event pulses and the byte values. A wrong internal state therefore shows up as a missing, extra or reordered event rather than as a subtle level error. A bit-phase counter that slips adds or drops a bit, which corrupts the next byte within eight bit times, or raises a stuffing error within seven bit times of a long run of 1s. A NRZI reference or stuffing counter that is off by one shows up in the very first byte of a packet with six 1s, or as a false `rx_stuff_err`. A wrong SE0 length count moves `rx_bus_reset` across the 119/120-sample boundary that the bench probes.

// File: rtl/usbfs_rx_pkg.sv
// Shared types for the full-speed line receiver.
// The line state encoding is {dp, dm}, so a synchronised pair can be cast directly.
package usbfs_rx_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_K   = 2'b01,
        LS_J   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    typedef enum logic [2:0] {
        FR_HUNT,
        FR_DATA,
        FR_SE0,
        FR_EOPW,
        FR_ABORT
    } frame_t;

endpackage

// File: rtl/usbfs_rx_line_sync.sv
// Brings the asynchronous line pair into the sampling clock domain through two
// flops and registers the classified line state.
// Assumes: dp/dm are glitch-free enough to need only metastability protection.
module usbfs_rx_line_sync
    import usbfs_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  dp,
    input  logic  dm,
    output line_t ls
);

    logic [1:0] meta_q;
    logic [1:0] sync_q;

    // Two-flop synchroniser, then classification into a line state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 2'b10;
            sync_q <= 2'b10;
            ls     <= LS_J;
        end else begin
            meta_q <= {dp, dm};
            sync_q <= meta_q;
            ls     <= line_t'(sync_q);
        end
    end

endmodule

// File: rtl/usbfs_rx_bit_clk.sv
// Recovers the bit timing from the oversampled line state. A phase counter
// is restarted on every change of line state, and one sample per bit is taken
// near the middle of the bit.
// Assumes: OSR >= 3, and the transmitter is within a sample of nominal between edges.
module usbfs_rx_bit_clk
    import usbfs_rx_pkg::*;
#(
    parameter int OSR = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  line_t ls,
    output logic  bit_stb,
    output line_t bit_ls
);

    localparam int CW   = (OSR > 2) ? $clog2(OSR) : 2;
    localparam int HALF = OSR / 2;

    line_t         prev_ls;
    logic [CW-1:0] phase;
    logic          line_edge;

    assign line_edge = (ls != prev_ls);

    // Phase tracking: restart on edges, wrap every OSR samples, strobe mid-bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ls <= LS_J;
            phase   <= '0;
            bit_stb <= 1'b0;
            bit_ls  <= LS_J;
        end else begin
            prev_ls <= ls;
            bit_stb <= 1'b0;
            if (line_edge) begin
                phase <= CW'(1);
            end else begin
                if (phase == CW'(OSR - 1)) begin
                    phase <= '0;
                end else begin
                    phase <= phase + 1'b1;
                end
                if (phase == CW'(HALF)) begin
                    bit_stb <= 1'b1;
                    bit_ls  <= ls;
                end
            end
        end
    end

endmodule

// File: rtl/usbfs_rx_nrzi.sv
// Turns mid-bit line samples into decoded bits: an unchanged J/K level gives 1,
// a change gives 0. SE0 bit times are reported separately, and the reference level
// returns to J after them (the line idles J after SE0). SE1 samples are dropped.
module usbfs_rx_nrzi
    import usbfs_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_stb,
    input  line_t bit_ls,
    output logic  dat_stb,
    output logic  dat_bit,
    output logic  se0_stb
);

    line_t ref_ls;

    // NRZI decode against the previous bit's level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_ls  <= LS_J;
            dat_stb <= 1'b0;
            dat_bit <= 1'b0;
            se0_stb <= 1'b0;
        end else begin
            dat_stb <= 1'b0;
            se0_stb <= 1'b0;
            if (bit_stb) begin
                case (bit_ls)
                    LS_J, LS_K: begin
                        dat_stb <= 1'b1;
                        dat_bit <= (bit_ls == ref_ls);
                        ref_ls  <= bit_ls;
                    end
                    LS_SE0: begin
                        se0_stb <= 1'b1;
                        ref_ls  <= LS_J;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/usbfs_rx_framer.sv
// Packet framing: hunts for SYNC, removes stuffed zeros, packs bytes LSB first,
// and closes a packet on EOP, a stuffing violation, a short SE0 or a bus reset.
// The bus-reset timer counts raw SE0 samples, so it works in any framing state.
module usbfs_rx_framer
    import usbfs_rx_pkg::*;
#(
    parameter int BYTE_W         = 8,
    parameter int STUFF_LEN      = 6,
    parameter int SYNC_MIN_ZEROS = 6,
    parameter int RST_CYCLES     = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_t             ls,
    input  logic              dat_stb,
    input  logic              dat_bit,
    input  logic              se0_stb,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_sop,
    output logic              rx_eop,
    output logic              rx_stuff_err,
    output logic              rx_frame_err,
    output logic              rx_bus_reset
);

    localparam int OW = $clog2(STUFF_LEN + 1);
    localparam int ZW = $clog2(SYNC_MIN_ZEROS + 1);
    localparam int RW = $clog2(RST_CYCLES + 1);
    localparam int BW = $clog2(BYTE_W);

    frame_t            state;
    logic [ZW-1:0]     zeros;
    logic [OW-1:0]     ones;
    logic [BYTE_W-1:0] shreg;
    logic [BW-1:0]     nbits;
    logic [RW-1:0]     se0_run;
    logic              rst_hit;

    assign rst_hit = (ls == LS_SE0) && (se0_run == RW'(RST_CYCLES - 1));

    // SE0 duration counter, saturating so the reset is reported once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            se0_run <= '0;
        end else if (ls != LS_SE0) begin
            se0_run <= '0;
        end else if (se0_run != RW'(RST_CYCLES)) begin
            se0_run <= se0_run + 1'b1;
        end
    end

    // Framing state machine and byte assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= FR_HUNT;
            zeros        <= '0;
            ones         <= '0;
            shreg        <= '0;
            nbits        <= '0;
            rx_valid     <= 1'b0;
            rx_byte      <= '0;
            rx_sop       <= 1'b0;
            rx_eop       <= 1'b0;
            rx_stuff_err <= 1'b0;
            rx_frame_err <= 1'b0;
            rx_bus_reset <= 1'b0;
        end else begin
            rx_valid     <= 1'b0;
            rx_sop       <= 1'b0;
            rx_eop       <= 1'b0;
            rx_stuff_err <= 1'b0;
            rx_frame_err <= 1'b0;
            rx_bus_reset <= 1'b0;
            if (rst_hit) begin
                rx_bus_reset <= 1'b1;
                state        <= FR_HUNT;
                zeros        <= '0;
            end else begin
                case (state)
                    FR_HUNT: begin
                        if (dat_stb) begin
                            if (!dat_bit) begin
                                if (zeros != ZW'(SYNC_MIN_ZEROS)) begin
                                    zeros <= zeros + 1'b1;
                                end
                            end else begin
                                if (zeros == ZW'(SYNC_MIN_ZEROS)) begin
                                    rx_sop <= 1'b1;
                                    state  <= FR_DATA;
                                    ones   <= OW'(1);
                                    nbits  <= '0;
                                end
                                zeros <= '0;
                            end
                        end else if (se0_stb) begin
                            zeros <= '0;
                        end
                    end
                    FR_DATA: begin
                        if (dat_stb) begin
                            if (ones == OW'(STUFF_LEN)) begin
                                if (dat_bit) begin
                                    rx_stuff_err <= 1'b1;
                                    state        <= FR_ABORT;
                                end
                                ones <= '0;
                            end else begin
                                ones  <= dat_bit ? ones + 1'b1 : '0;
                                shreg <= {dat_bit, shreg[BYTE_W-1:1]};
                                if (nbits == BW'(BYTE_W - 1)) begin
                                    rx_valid <= 1'b1;
                                    rx_byte  <= {dat_bit, shreg[BYTE_W-1:1]};
                                    nbits    <= '0;
                                end else begin
                                    nbits <= nbits + 1'b1;
                                end
                            end
                        end else if (se0_stb) begin
                            state <= FR_SE0;
                        end
                    end
                    FR_SE0: begin
                        if (se0_stb) begin
                            state <= FR_EOPW;
                        end else if (dat_stb) begin
                            rx_frame_err <= 1'b1;
                            state        <= FR_HUNT;
                            zeros        <= '0;
                        end
                    end
                    FR_EOPW: begin
                        if (dat_stb) begin
                            rx_eop <= 1'b1;
                            state  <= FR_HUNT;
                            zeros  <= '0;
                        end
                    end
                    FR_ABORT: begin
                        if (se0_stb) begin
                            state <= FR_HUNT;
                            zeros <= '0;
                        end
                    end
                    default: begin
                        state <= FR_HUNT;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/usbfs_line_rx.sv
// Top of the full-speed line receiver: synchroniser, bit clock recovery,
// NRZI decoder and framer in a chain. Every output is a registered one-cycle pulse,
// except rx_byte, which holds its value between strobes.
module usbfs_line_rx
    import usbfs_rx_pkg::*;
#(
    parameter int OSR            = 4,
    parameter int BYTE_W         = 8,
    parameter int STUFF_LEN      = 6,
    parameter int SYNC_MIN_ZEROS = 6,
    parameter int RST_CYCLES     = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dp,
    input  logic              dm,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_sop,
    output logic              rx_eop,
    output logic              rx_stuff_err,
    output logic              rx_frame_err,
    output logic              rx_bus_reset
);

    line_t ls;
    line_t bit_ls;
    logic  bit_stb;
    logic  dat_stb;
    logic  dat_bit;
    logic  se0_stb;

    usbfs_rx_line_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .dp    (dp),
        .dm    (dm),
        .ls    (ls)
    );

    usbfs_rx_bit_clk #(
        .OSR (OSR)
    ) u_bclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .ls      (ls),
        .bit_stb (bit_stb),
        .bit_ls  (bit_ls)
    );

    usbfs_rx_nrzi u_nrzi (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_stb (bit_stb),
        .bit_ls  (bit_ls),
        .dat_stb (dat_stb),
        .dat_bit (dat_bit),
        .se0_stb (se0_stb)
    );

    usbfs_rx_framer #(
        .BYTE_W         (BYTE_W),
        .STUFF_LEN      (STUFF_LEN),
        .SYNC_MIN_ZEROS (SYNC_MIN_ZEROS),
        .RST_CYCLES     (RST_CYCLES)
    ) u_frm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ls           (ls),
        .dat_stb      (dat_stb),
        .dat_bit      (dat_bit),
        .se0_stb      (se0_stb),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .rx_sop       (rx_sop),
        .rx_eop       (rx_eop),
        .rx_stuff_err (rx_stuff_err),
        .rx_frame_err (rx_frame_err),
        .rx_bus_reset (rx_bus_reset)
    );

endmodule

// File: rtl/usbfs_line_rx_chk.sv
// Port-level protocol checker for usbfs_line_rx. It tracks whether a packet is open
// from the event pulses alone and checks the ordering rules against that.
module usbfs_line_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic rx_sop,
    input logic rx_eop,
    input logic rx_stuff_err,
    input logic rx_frame_err,
    input logic rx_bus_reset
);

    logic in_pkt;

    // Open a packet on a start pulse, close it on any terminating pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt <= 1'b0;
        end else if (rx_sop) begin
            in_pkt <= 1'b1;
        end else if (rx_eop || rx_stuff_err || rx_frame_err || rx_bus_reset) begin
            in_pkt <= 1'b0;
        end
    end

    // R11
    event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, rx_sop, rx_eop, rx_stuff_err, rx_frame_err, rx_bus_reset}));

    // R4
    byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R11
    byte_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> in_pkt);

    // R7
    eop_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eop |-> in_pkt);

    // R2
    sop_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sop |-> !in_pkt);

    // R6
    stuff_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stuff_err |-> in_pkt);

    // R8
    frame_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |-> in_pkt);

endmodule

bind usbfs_line_rx usbfs_line_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_sop       (rx_sop),
    .rx_eop       (rx_eop),
    .rx_stuff_err (rx_stuff_err),
    .rx_frame_err (rx_frame_err),
    .rx_bus_reset (rx_bus_reset)
);

// File: tb/usbfs_line_rx_tb.sv
// Scoreboard bench: the driver encodes packets onto the lines and queues the
// expected events, and the monitor pops and compares every event pulse it sees.
module usbfs_line_rx_tb;

    localparam logic [1:0] LV_J   = 2'b10;
    localparam logic [1:0] LV_K   = 2'b01;
    localparam logic [1:0] LV_SE0 = 2'b00;

    localparam int EV_SOP = 1, EV_BYTE = 2, EV_EOP = 3, EV_STUFF = 4, EV_FRAME = 5, EV_RST = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] line = LV_J;
    logic       rx_valid, rx_sop, rx_eop, rx_stuff_err, rx_frame_err, rx_bus_reset;
    logic [7:0] rx_byte;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    int  exp_q[$];
    bit  bits[$];
    logic [1:0] lvl = LV_J;
    int  bo = 0;
    bit  alt = 1'b0;

    always #4 clk = ~clk;

    usbfs_line_rx u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .dp           (line[1]),
        .dm           (line[0]),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .rx_sop       (rx_sop),
        .rx_eop       (rx_eop),
        .rx_stuff_err (rx_stuff_err),
        .rx_frame_err (rx_frame_err),
        .rx_bus_reset (rx_bus_reset)
    );

    function automatic string req_of(input int code);
        case (code >> 8)
            EV_SOP:   return "R2";
            EV_BYTE:  return "R4";
            EV_EOP:   return "R7";
            EV_STUFF: return "R6";
            EV_FRAME: return "R8";
            default:  return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic observe(input int code);
        int e;
        if (exp_q.size() == 0) begin
            check(1'b0, req_of(code), code, 0);
        end else begin
            e = exp_q.pop_front();
            check(code == e, req_of(e), code, e);
        end
    endtask

    // Monitor: samples the event pulses between clock edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_sop)       observe(EV_SOP << 8);
            if (rx_valid)     observe((EV_BYTE << 8) | int'(rx_byte));
            if (rx_eop)       observe(EV_EOP << 8);
            if (rx_stuff_err) observe(EV_STUFF << 8);
            if (rx_frame_err) observe(EV_FRAME << 8);
            if (rx_bus_reset) observe(EV_RST << 8);
        end
    end

    task automatic hold(input logic [1:0] lv, input int n);
        line = lv;
        repeat (n) @(negedge clk);
    endtask

    // R1/R3: J/K encoding and NRZI; a 0 bit toggles the level.
    task automatic tx_bit(input bit b, input int w);
        if (!b) lvl = (lvl == LV_J) ? LV_K : LV_J;
        hold(lvl, w);
    endtask

    task automatic push_sync(input int nzeros);
        for (int i = 0; i < nzeros; i++) bits.push_back(1'b0);
        bits.push_back(1'b1);
        bo = 1;
    endtask

    task automatic push_byte(input logic [7:0] b, input bit expect_it);
        for (int i = 0; i < 8; i++) begin
            bits.push_back(b[i]);
            bo = b[i] ? bo + 1 : 0;
            if (bo == 6) begin
                bits.push_back(1'b0);
                bo = 0;
            end
        end
        if (expect_it) exp_q.push_back((EV_BYTE << 8) | int'(b));
    endtask

    // R10: in stretch mode, bits followed by an edge are 3 or 5 samples wide.
    task automatic send_bits(input bit stretch);
        for (int i = 0; i < bits.size(); i++) begin
            bit nxt_edge;
            int w;
            nxt_edge = (i == bits.size() - 1) || (bits[i + 1] == 1'b0);
            w = 4;
            if (stretch && nxt_edge) begin
                w = alt ? 3 : 5;
                alt = !alt;
            end
            tx_bit(bits[i], w);
        end
        bits.delete();
    endtask

    task automatic end_se0(input int se0_len);
        hold(LV_SE0, se0_len);
        lvl = LV_J;
        hold(LV_J, 40);
    endtask

    task automatic drained(input string req);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic send_packet(input logic [7:0] d0, input logic [7:0] d1,
                               input logic [7:0] d2, input logic [7:0] d3,
                               input int n, input bit stretch);
        logic [7:0] d [4];
        d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
        exp_q.push_back(EV_SOP << 8);
        push_sync(7);
        for (int i = 0; i < n; i++) push_byte(d[i], 1'b1);
        send_bits(stretch);
        exp_q.push_back(EV_EOP << 8);
        end_se0(8);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (5) @(negedge clk);
        // R12: all outputs low during reset.
        check({rx_valid, rx_sop, rx_eop, rx_stuff_err, rx_frame_err, rx_bus_reset} == 6'b0,
              "R12", {rx_valid, rx_sop, rx_eop, rx_stuff_err, rx_frame_err, rx_bus_reset}, 0);
        check(rx_byte == 8'h00, "R12", rx_byte, 0);
        rst_n = 1'b1;
        hold(LV_J, 20);
        check({rx_valid, rx_sop, rx_eop, rx_stuff_err, rx_frame_err, rx_bus_reset} == 6'b0,
              "R12", {rx_valid, rx_sop, rx_eop, rx_stuff_err, rx_frame_err, rx_bus_reset}, 0);

        // R1 R3 R4 R7: plain packet, idle J after reset.
        send_packet(8'hA5, 8'h3C, 8'h00, 8'h81, 4, 1'b0);
        drained("R1");

        // R5: long runs of ones force stuffed zeros.
        send_packet(8'hFF, 8'hFF, 8'h7E, 8'h80, 4, 1'b0);
        drained("R5");

        // R10: edge-bounded bits at 3 and 5 samples.
        send_packet(8'h5A, 8'hF0, 8'h0F, 8'hC3, 4, 1'b1);
        drained("R10");

        // R2: five zeros then a one opens no packet.
        push_sync(5);
        send_bits(1'b0);
        end_se0(8);
        drained("R2");

        // R6: seven ones without a stuffed zero, then SE0; no end of packet.
        exp_q.push_back(EV_SOP << 8);
        push_sync(7);
        push_byte(8'h00, 1'b1);
        for (int i = 0; i < 7; i++) bits.push_back(1'b1);
        exp_q.push_back(EV_STUFF << 8);
        send_bits(1'b0);
        end_se0(8);
        drained("R6");

        // R8: single SE0 bit time ends the packet with a framing error.
        exp_q.push_back(EV_SOP << 8);
        push_sync(7);
        push_byte(8'h42, 1'b1);
        send_bits(1'b0);
        exp_q.push_back(EV_FRAME << 8);
        end_se0(4);
        drained("R8");

        // R9: SE0 one sample short of the reset threshold is not a reset.
        end_se0(119);
        drained("R9");

        // R9: long SE0 while idle.
        exp_q.push_back(EV_RST << 8);
        end_se0(200);
        drained("R9");

        // R9: long SE0 inside a packet gives a reset and no end of packet.
        exp_q.push_back(EV_SOP << 8);
        push_sync(7);
        push_byte(8'h99, 1'b1);
        send_bits(1'b0);
        exp_q.push_back(EV_RST << 8);
        end_se0(200);
        drained("R9");

        // R11: receiver still frames correctly after every error case.
        send_packet(8'h2D, 8'hFE, 8'h00, 8'h00, 2, 1'b1);
        drained("R11");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule